// File: doc/BRIEF.md
# Periodic Interrupt Tick Divider

This block turns a 32768 Hz time base into periodic interrupt ticks. The time base arrives as a one-cycle enable strobe in the system clock domain. The block counts the strobes on a free-running counter. A 4-bit rate code sets the tick period as a power of two of base cycles, and an enable input decides whether any tick is produced at all.

A tick falls on every strobe that brings the count to a multiple of the current period. Changing the rate does not restart the count, so the ticks stay aligned to absolute multiples of the period. Each tick gives a one-cycle pulse that sets the periodic flag and a matching one-cycle request for the shared interrupt line. The register that holds the flag is kept outside this block.

Top module: `periodic_tick_gen`

## Requirements
- R1: While and directly after a synchronous reset, both outputs are low and the strobe count is zero.
- R2: The strobe count is a 16-bit free-running counter. It advances by one on every `base_stb` strobe, whatever the rate code and enable are.
- R3: For an effective code n in 3..15, a tick occurs on a strobe whose post-increment count is a multiple of 2^(n-1) base cycles.
- R4: Rate code 1 behaves as effective code 8, giving a period of 128. Rate code 2 behaves as effective code 9, giving a period of 256.
- R5: Rate code 0 produces no ticks on either output.
- R6: With `tick_en` low, no tick is produced on either output.
- R7: A change of rate code keeps the phase. After the change, the next tick falls on the next absolute multiple of the new period.
- R8: A tick appears on the outputs exactly one clock after the strobe that causes it and lasts one clock. Cycles without a strobe never produce a tick.
- R9: `irq_req` pulses in exactly the cycles in which `flag_set` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| base_stb | input | 1 | One-cycle strobe per 32768 Hz base cycle |
| rate_code | input | 4 | Rate select. 0 stops ticks; 1 and 2 are aliased to slow rates |
| tick_en | input | 1 | Periodic interrupt enable |
| flag_set | output | 1 | One-cycle pulse that sets the periodic flag |
| irq_req | output | 1 | One-cycle request to raise the interrupt line |

## Verification
The hardest case to reach is the phase rule. A rate change has to land at a count that is not a multiple of the new period, and the tick must then appear at the next absolute multiple rather than one full period after the change. The bench first advances the counter with ticks disabled. It then switches the code part-way through a period and predicts each tick from its own strobe count since reset. It also runs the longest period and both aliased codes in full, so the tick spacing is checked over many strobes.

// File: rtl/periodic_tick_pkg.sv
package periodic_tick_pkg;
   // Map a raw rate code to the effective exponent code n (period = 2^(n-1)).
   function automatic int eff_code(input int code, input bit alias_slow);
      int n;
      n = code;
      if (alias_slow && code == 1) n = 8;
      if (alias_slow && code == 2) n = 9;
      return n;
   endfunction
endpackage

// File: rtl/strobe_counter.sv
module strobe_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   output logic [CNT_W-1:0] cnt_next
);
   logic [CNT_W-1:0] cnt_q;

   assign cnt_next = cnt_q + CNT_W'(1);

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (step) cnt_q <= cnt_next;
   end
endmodule

// File: rtl/rate_decode.sv
module rate_decode
   import periodic_tick_pkg::*;
#(
   parameter int CODE_W     = 4,
   parameter int CNT_W      = 16,
   parameter bit ALIAS_SLOW = 1'b1
) (
   input  logic [CODE_W-1:0] code,
   output logic              active,
   output logic [CNT_W-1:0]  mask
);
   localparam int MAX_CODE = (1 << CODE_W) - 1;

   int n;

   generate
      if (ALIAS_SLOW) begin : g_alias
         always_comb n = eff_code(int'(code), 1'b1);
      end else begin : g_linear
         always_comb n = eff_code(int'(code), 1'b0);
      end
   endgenerate

   always_comb begin
      active = (code != '0);
      mask   = '0;
      if (active && n > 1 && n <= MAX_CODE)
         mask = (CNT_W'(1) << (n - 1)) - CNT_W'(1);
   end
endmodule

// File: rtl/periodic_tick_gen.sv
module periodic_tick_gen #(
   parameter int CODE_W     = 4,
   parameter int CNT_W      = 16,
   parameter bit ALIAS_SLOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              base_stb,
   input  logic [CODE_W-1:0] rate_code,
   input  logic              tick_en,
   output logic              flag_set,
   output logic              irq_req
);
   localparam int NEED_W = (1 << CODE_W) - 2;

   generate
      if (CNT_W < NEED_W) begin : g_bad_width
         $error("periodic_tick_gen: CNT_W too narrow for longest period");
      end
      if (CODE_W < 2) begin : g_bad_code
         $error("periodic_tick_gen: CODE_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_next;
   logic [CNT_W-1:0] mask;
   logic             active;
   logic             tick_q;

   strobe_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .step     (base_stb),
      .cnt_next (cnt_next)
   );

   rate_decode #(
      .CODE_W     (CODE_W),
      .CNT_W      (CNT_W),
      .ALIAS_SLOW (ALIAS_SLOW)
   ) u_dec (
      .code   (rate_code),
      .active (active),
      .mask   (mask)
   );

   always_ff @(posedge clk) begin
      if (rst) tick_q <= 1'b0;
      else     tick_q <= base_stb && tick_en && active && ((cnt_next & mask) == '0);
   end

   assign flag_set = tick_q;
   assign irq_req  = tick_q;
endmodule

// File: rtl/periodic_tick_chk.sv
module periodic_tick_chk #(
   parameter int CODE_W = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              base_stb,
   input logic [CODE_W-1:0] rate_code,
   input logic              tick_en,
   input logic              flag_set,
   input logic              irq_req
);
   AST_TICK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
      flag_set |-> $past(base_stb)); // R8
   AST_TICK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
      flag_set |-> $past(tick_en)); // R6
   AST_TICK_NEEDS_CODE: assert property (@(posedge clk) disable iff (rst)
      flag_set |-> ($past(rate_code) != '0)); // R5
   AST_IRQ_MATCHES_FLAG: assert property (@(posedge clk) disable iff (rst)
      irq_req == flag_set); // R9
   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
      irq_req |-> $past(tick_en)); // R6
endmodule

bind periodic_tick_gen periodic_tick_chk #(.CODE_W(CODE_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .base_stb  (base_stb),
   .rate_code (rate_code),
   .tick_en   (tick_en),
   .flag_set  (flag_set),
   .irq_req   (irq_req)
);

// File: tb/periodic_tick_gen_test.sv
module periodic_tick_gen_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       base_stb = 1'b0;
   logic [3:0] rate_code = 4'd0;
   logic       tick_en = 1'b0;
   logic       flag_set, irq_req;

   int total = 0;
   int bad = 0;
   int ticks_seen = 0;
   logic [15:0] m_cnt = '0;
   bit done = 0;

   always #4 clk = ~clk;

   periodic_tick_gen uut (
      .clk(clk), .rst(rst), .base_stb(base_stb), .rate_code(rate_code),
      .tick_en(tick_en), .flag_set(flag_set), .irq_req(irq_req)
   );

   function automatic int period_of(input logic [3:0] c);
      if (c == 4'd1) return 128;
      if (c == 4'd2) return 256;
      return 1 << (int'(c) - 1);
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b (count=%0d code=%0d en=%0b)",
                  req, act, exp, m_cnt, rate_code, tick_en);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1; base_stb = 1'b0;
      @(negedge clk); @(negedge clk);
      check("R1", flag_set, 1'b0);
      check("R1", irq_req, 1'b0);
      rst = 1'b0; m_cnt = '0;
   endtask

   // One base strobe; checks tick one clock later and its one-clock width.
   task automatic strobe(input string req);
      logic exp;
      @(negedge clk); base_stb = 1'b1;
      @(negedge clk); base_stb = 1'b0;
      m_cnt = m_cnt + 16'd1;
      exp = tick_en && (rate_code != 0) && ((int'(m_cnt) % period_of(rate_code)) == 0);
      check(req, flag_set, exp);
      check("R9", irq_req, exp);
      if (flag_set) ticks_seen++;
      @(negedge clk);
      check("R8", flag_set, 1'b0);
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk);
      check("R1", flag_set, 1'b0);
   endtask

   task automatic t_periods();
      tick_en = 1'b1;
      rate_code = 4'd3; repeat (16) strobe("R3");
      rate_code = 4'd6; repeat (64) strobe("R3");
      rate_code = 4'd15; ticks_seen = 0;
      repeat (16384) strobe("R3");
      check("R3", logic'(ticks_seen == 1), 1'b1);
   endtask

   task automatic t_alias();
      do_reset();
      tick_en = 1'b1;
      rate_code = 4'd1; ticks_seen = 0;
      repeat (256) strobe("R4");
      check("R4", logic'(ticks_seen == 2), 1'b1);
      rate_code = 4'd2; ticks_seen = 0;
      repeat (512) strobe("R4");
      check("R4", logic'(ticks_seen == 2), 1'b1);
   endtask

   task automatic t_stop();
      do_reset();
      tick_en = 1'b1; rate_code = 4'd0;
      repeat (64) strobe("R5");
      rate_code = 4'd3; tick_en = 1'b0; ticks_seen = 0;
      repeat (64) strobe("R6");
      check("R6", logic'(ticks_seen == 0), 1'b1);
   endtask

   task automatic t_phase();
      do_reset();
      // advance counter with ticks disabled, then enable (R2)
      tick_en = 1'b0; rate_code = 4'd4;
      repeat (5) strobe("R2");
      tick_en = 1'b1;
      repeat (3) strobe("R2");   // count 8: tick on absolute multiple
      repeat (2) strobe("R7");   // count 10
      rate_code = 4'd5;           // period 16: next tick at 16, not 26
      repeat (6) strobe("R7");
      check("R7", logic'(m_cnt == 16'd16), 1'b1);
      rate_code = 4'd3;
      repeat (9) strobe("R7");
   endtask

   task automatic t_no_strobe();
      tick_en = 1'b1; rate_code = 4'd3;
      repeat (20) begin
         @(negedge clk);
         check("R8", flag_set, 1'b0);
      end
   endtask

   initial begin
      t_reset();
      t_periods();
      t_alias();
      t_stop();
      t_phase();
      t_no_strobe();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule